// File: doc/BRIEF.md
# Paced Byte Transmitter with Pin-Controlled Enable

This block sits between a transmit byte queue and a serial line encoder in a UART transport endpoint. While the endpoint is enabled, it offers the byte at the head of the queue once per baud interval. The interval is a count of system clock cycles, worked out from a clock-frequency parameter and the line speed last written. An iterative divider inside the block produces that count.

Two control pins set the endpoint's lifecycle. A high-to-low edge on the reset pin disables the endpoint. It also sends a one-cycle flush pulse to the neighbouring queue, receive and address logic, and puts the interval and CTS back to their defaults. The endpoint is enabled only when the pin pair moves into the state where both pins are high.

The block also keeps the CTS line. CTS is raised after reset and on every speed write, and it is dropped when RTS is released.

The outgoing byte stream uses valid/ready with a strict back-pressure rule. `tx_valid_o` is offered for a single cycle at each interval tick. The byte counts as taken only if `tx_ready_i` is high in that same cycle. If it is not taken, the queue head stays where it is and is offered again at the next tick; the offer is not held. The queue side is a read port: `q_ready_o` is the pop strobe, and it is high exactly when a byte is taken.

Top module: `paced_tx_ctrl`

## Requirements
- R1: A high-to-low edge on `pins_i[0]` (the reset pin) has four effects. It clears `enable_o` at that clock edge. It drives `flush_o` high for exactly one cycle. It returns the interval to CLK_HZ cycles. It raises `cts_o`.
- R2: `enable_o` becomes 1 only when `pins_i` changes to 2'b11 from any other value; the pin history starts at 2'b00 when `rst_n` is released. Holding 2'b11, or lowering only `pins_i[1]`, does not change `enable_o`.
- R3: While `enable_o` is 0, `tx_valid_o` and `q_ready_o` stay 0, even with a queued byte and a ready consumer.
- R4: The interval is floor(CLK_HZ / speed) cycles, with a minimum of 1 cycle. After reset it is CLK_HZ cycles, which is one second.
- R5: While the endpoint is enabled and `q_valid_i` is high, `tx_valid_o` is a one-cycle pulse that repeats exactly once per interval.
- R6: A byte is popped (`q_ready_o` = 1) only in an offer cycle where `tx_ready_i` is 1. Otherwise the same head byte is offered again at the next tick.
- R7: `cts_o` is 1 after reset and becomes 1 on every write of a nonzero speed.
- R8: A 1-to-0 change of `rts_i` clears `cts_o` at the next edge. A 0-to-1 change has no effect. A nonzero speed write in the same cycle wins, and `cts_o` stays 1.
- R9: A speed write with `speed_i` = 0 is ignored: the interval and `cts_o` are unchanged.
- R10: Bytes leave on `tx_data_o` in queue order, each equal to the queue head at the moment it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 2 | Control pins: bit 0 is the reset pin, bit 1 is the wake pin |
| rts_i | input | 1 | RTS from the host side |
| speed_wr_i | input | 1 | One-cycle strobe that writes a new line speed |
| speed_i | input | SPD_W | Line speed in symbols per second |
| q_valid_i | input | 1 | The transmit queue holds a byte |
| q_data_i | input | DATA_W | Byte at the head of the queue |
| q_ready_o | output | 1 | Pop strobe for the queue head |
| tx_valid_o | output | 1 | One-cycle byte offer at an interval tick |
| tx_data_o | output | DATA_W | Offered byte |
| tx_ready_i | input | 1 | Consumer accepts the byte in the offer cycle |
| cts_o | output | 1 | CTS line |
| enable_o | output | 1 | Endpoint enabled |
| flush_o | output | 1 | One-cycle clear pulse for the queue, receive and address state |

## Verification
The pacing is measured as the distance between consecutive offers. This is done for the default one-second interval, for speeds that divide CLK_HZ exactly and inexactly, and for a speed above CLK_HZ. Together these separate a correct floor division from rounding errors and from the clamp to one cycle. A stalled consumer is held across several ticks to tell "reoffer the same head" apart from "drop or advance the byte". The pin pair is walked through partial states, wake-only drops and reset-pin falls to confirm that only entry into both-high enables the endpoint. RTS edges are applied alone and together with speed writes to show the set-over-clear priority on CTS.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int PIN_RST  = 0;
  localparam int PIN_WAKE = 1;
  localparam logic [1:0] PINS_ALL = 2'b11;
endpackage

// File: rtl/ptx_pins.sv
module ptx_pins
  import ptx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pins_i,
  output logic       en_o,
  output logic       flush_o
);
  logic [1:0] prev_q;
  logic       en_q;
  logic       flush_q;
  logic       rst_fall;
  logic       arm;

  assign rst_fall = prev_q[PIN_RST] & ~pins_i[PIN_RST];
  assign arm      = (pins_i == PINS_ALL) && (prev_q != PINS_ALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 2'b00;
      en_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      prev_q  <= pins_i;
      flush_q <= rst_fall;
      if (rst_fall)  en_q <= 1'b0;
      else if (arm)  en_q <= 1'b1;
    end
  end

  assign en_o    = en_q;
  assign flush_o = flush_q;

  // R2: enable only ever rises after the pins were seen both high
  a_r2_enable_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(pins_i) == PINS_ALL);
  // R1: a flush pulse never coexists with an enabled endpoint
  a_r1_flush_disables: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !en_q);
  // R1: flush lasts a single cycle
  a_r1_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);
endmodule

// File: rtl/ptx_div.sv
module ptx_div #(
  parameter longint DIVIDEND = 100_000_000,
  parameter int     NUM_W    = 27,
  parameter int     DEN_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DEN_W-1:0] den_i,
  input  logic             cancel_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int IDX_W = $clog2(NUM_W);
  localparam logic [NUM_W-1:0] NUM = NUM_W'(DIVIDEND);

  logic             busy_q;
  logic             done_q;
  logic [IDX_W-1:0] idx_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             ge;

  assign trial = {rem_q, NUM[idx_q]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (cancel_i) begin
        busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= IDX_W'(NUM_W - 1);
        rem_q  <= '0;
        den_q  <= den_i;
        quo_q  <= '0;
      end else if (busy_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], ge};
        if (idx_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R4: a result only appears at the end of a running division
  a_r4_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));
  // R9: a zero divisor is never loaded into a division
  a_r9_no_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> den_q != '0);
endmodule

// File: rtl/ptx_pacer.sv
module ptx_pacer #(
  parameter int     CNT_W   = 27,
  parameter longint DEFAULT = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             flush_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             q_valid_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic             pop_o
);
  localparam logic [CNT_W-1:0] DEF_IVL = CNT_W'(DEFAULT);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] ivl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = en_i && (cnt_q == ivl_q - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q <= DEF_IVL;
      cnt_q <= '0;
    end else begin
      if (flush_i)   ivl_q <= DEF_IVL;
      else if (ld_i) ivl_q <= (ld_val_i == '0) ? ONE : ld_val_i;
      if (!en_i || flush_i || ld_i || tick) cnt_q <= '0;
      else                                  cnt_q <= cnt_q + ONE;
    end
  end

  assign tx_valid_o = tick && q_valid_i;
  assign pop_o      = tx_valid_o && tx_ready_i;

  // R3: nothing is offered while disabled
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> en_i);
  // R5: offers are separated by the interval when it exceeds one cycle
  a_r5_one_per_interval: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && ivl_q > ONE) |=> !tx_valid_o);
  // R4: the interval is never zero
  a_r4_nonzero_interval: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_q != '0);
endmodule

// File: rtl/ptx_modem.sv
module ptx_modem (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rts_i,
  output logic cts_o
);
  logic rts_q;
  logic cts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rts_q <= 1'b0;
      cts_q <= 1'b1;
    end else begin
      rts_q <= rts_i;
      if (set_i)                cts_q <= 1'b1;
      else if (rts_q && !rts_i) cts_q <= 1'b0;
    end
  end

  assign cts_o = cts_q;

  // R8: CTS rises only because of a set request
  a_r8_cts_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_q) |-> $past(set_i));
endmodule

// File: rtl/paced_tx_ctrl.sv
module paced_tx_ctrl #(
  parameter longint CLK_HZ = 100_000_000,
  parameter int     SPD_W  = 24,
  parameter int     DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pins_i,
  input  logic              rts_i,
  input  logic              speed_wr_i,
  input  logic [SPD_W-1:0]  speed_i,
  input  logic              q_valid_i,
  input  logic [DATA_W-1:0] q_data_i,
  output logic              q_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              cts_o,
  output logic              enable_o,
  output logic              flush_o
);
  localparam int CNT_W = $clog2(CLK_HZ + 1);

  logic             en;
  logic             flush;
  logic             start;
  logic             div_done;
  logic [CNT_W-1:0] div_quo;

  assign start = speed_wr_i && (speed_i != '0);

  ptx_pins u_pins (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .en_o(en), .flush_o(flush)
  );

  ptx_div #(.DIVIDEND(CLK_HZ), .NUM_W(CNT_W), .DEN_W(SPD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(start), .den_i(speed_i),
    .cancel_i(flush), .done_o(div_done), .quo_o(div_quo)
  );

  ptx_pacer #(.CNT_W(CNT_W), .DEFAULT(CLK_HZ)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en_i(en), .flush_i(flush),
    .ld_i(div_done), .ld_val_i(div_quo), .q_valid_i(q_valid_i),
    .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o), .pop_o(q_ready_o)
  );

  ptx_modem u_modem (
    .clk(clk), .rst_n(rst_n), .set_i(flush | start), .rts_i(rts_i),
    .cts_o(cts_o)
  );

  assign tx_data_o = q_data_i;
  assign enable_o  = en;
  assign flush_o   = flush;

  // R6: a pop happens only on an accepted offer
  a_r6_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready_o |-> (tx_valid_o && tx_ready_i));
  // R8: releasing RTS with no write or flush drops CTS
  a_r8_rts_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rts_i) && !rts_i && !start && !flush) |=> !cts_o);
  // R7: a nonzero speed write raises CTS
  a_r7_write_sets_cts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cts_o);
endmodule

// File: tb/sim_paced_tx_ctrl.sv
module sim_paced_tx_ctrl;
  localparam longint CLK_HZ = 2000;
  localparam int SPD_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pins_i = 2'b00;
  logic        rts_i = 1'b0;
  logic        speed_wr_i = 1'b0;
  logic [15:0] speed_i = '0;
  logic        q_valid_i = 1'b0;
  logic [7:0]  q_data_i = 8'h30;
  logic        q_ready_o, tx_valid_o, tx_ready_i, cts_o, enable_o, flush_o;
  logic [7:0]  tx_data_o;

  int checks = 0, fails = 0;
  int cyc = 0, nvalid = 0, npop = 0, prev_st = 0, last_st = 0;
  logic [7:0] exp_pop = 8'h30;
  logic pop_pend = 1'b0;

  initial tx_ready_i = 1'b1;
  always #5 clk = ~clk;

  paced_tx_ctrl #(.CLK_HZ(CLK_HZ), .SPD_W(SPD_W), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .rts_i(rts_i),
    .speed_wr_i(speed_wr_i), .speed_i(speed_i), .q_valid_i(q_valid_i),
    .q_data_i(q_data_i), .q_ready_o(q_ready_o), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i), .cts_o(cts_o),
    .enable_o(enable_o), .flush_o(flush_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: stamps offers, checks popped data order (R10)
  initial forever begin
    @(negedge clk);
    cyc++;
    if (tx_valid_o) begin prev_st = last_st; last_st = cyc; nvalid++; end
    if (q_ready_o) begin
      npop++;
      check(tx_data_o == exp_pop, "R10 data order", tx_data_o, exp_pop);
      exp_pop = exp_pop + 8'd1;
      pop_pend = 1'b1;
    end
  end

  initial forever begin
    @(posedge clk);
    #1;
    if (pop_pend) begin q_data_i = q_data_i + 8'd1; pop_pend = 1'b0; end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic step_pins(input logic [1:0] v);
    @(negedge clk); pins_i = v;
    @(negedge clk);
  endtask

  task automatic write_speed(input int v, input bit rts_drop);
    @(negedge clk); speed_wr_i = 1'b1; speed_i = 16'(v);
    if (rts_drop) rts_i = 1'b0;
    @(negedge clk); speed_wr_i = 1'b0;
  endtask

  task automatic measure(input int exp, input string req);
    int n0;
    n0 = nvalid;
    while (nvalid < n0 + 2) @(negedge clk);
    check(last_st - prev_st == exp, req, last_st - prev_st, exp);
  endtask

  task automatic t_reset_state;
    check(cts_o == 1'b1, "R7 cts after reset", cts_o, 1);
    check(enable_o == 1'b0, "R2 disabled after reset", enable_o, 0);
    check(tx_valid_o == 1'b0, "R3 no offer after reset", tx_valid_o, 0);
  endtask

  task automatic t_disabled;
    q_valid_i = 1'b1;
    repeat (2500) @(negedge clk);
    check(nvalid == 0, "R3 no offers while disabled", nvalid, 0);
    check(npop == 0, "R3 no pops while disabled", npop, 0);
  endtask

  task automatic t_pins;
    step_pins(2'b01);
    check(enable_o == 1'b0, "R2 reset pin only", enable_o, 0);
    step_pins(2'b10);
    check(enable_o == 1'b0, "R2 wake pin only", enable_o, 0);
    step_pins(2'b11);
    check(enable_o == 1'b1, "R2 entry into both high", enable_o, 1);
    step_pins(2'b01);
    check(enable_o == 1'b1, "R2 wake drop keeps enable", enable_o, 1);
    step_pins(2'b11);
    check(enable_o == 1'b1, "R2 re-entry stays enabled", enable_o, 1);
  endtask

  task automatic t_speeds;
    measure(2000, "R4 default interval one second");
    write_speed(200, 1'b0);
    repeat (40) @(negedge clk);
    check(cts_o == 1'b1, "R7 cts after write", cts_o, 1);
    measure(10, "R4 R5 exact interval 10");
    write_speed(3, 1'b0);
    repeat (40) @(negedge clk);
    measure(666, "R4 floor interval 666");
    write_speed(4000, 1'b0);
    repeat (40) @(negedge clk);
    measure(1, "R4 clamp interval 1");
    write_speed(500, 1'b0);
    repeat (40) @(negedge clk);
    measure(4, "R5 interval 4");
  endtask

  task automatic t_cts;
    @(negedge clk); rts_i = 1'b1;
    @(negedge clk); rts_i = 1'b0;
    @(negedge clk);
    check(cts_o == 1'b0, "R8 rts release clears cts", cts_o, 0);
    rts_i = 1'b1;
    repeat (2) @(negedge clk);
    check(cts_o == 1'b0, "R8 rts rise no effect", cts_o, 0);
    write_speed(500, 1'b1);
    check(cts_o == 1'b1, "R8 write wins over rts release", cts_o, 1);
  endtask

  task automatic t_zero;
    @(negedge clk); rts_i = 1'b1;
    @(negedge clk); rts_i = 1'b0;
    write_speed(0, 1'b0);
    repeat (40) @(negedge clk);
    check(cts_o == 1'b0, "R9 zero write leaves cts", cts_o, 0);
    measure(4, "R9 zero write leaves interval");
  endtask

  task automatic t_backpressure;
    int p0, v0;
    logic [7:0] head;
    @(negedge clk); tx_ready_i = 1'b0;
    @(negedge clk);
    p0 = npop; v0 = nvalid; head = q_data_i;
    repeat (20) @(negedge clk);
    check(npop == p0, "R6 no pop while stalled", npop, p0);
    check(nvalid >= v0 + 4, "R6 reoffered each tick", nvalid - v0, 4);
    check(q_data_i == head, "R6 head kept", q_data_i, head);
    tx_ready_i = 1'b1;
    while (npop == p0) @(negedge clk);
    check(exp_pop == head + 8'd1, "R6 stalled head popped next", exp_pop, head + 8'd1);
  endtask

  task automatic t_reset_pin;
    @(negedge clk); rts_i = 1'b1;
    @(negedge clk); rts_i = 1'b0;
    @(negedge clk); pins_i = 2'b10;
    @(negedge clk);
    check(flush_o == 1'b1, "R1 flush pulse", flush_o, 1);
    check(enable_o == 1'b0, "R1 disabled", enable_o, 0);
    @(negedge clk);
    check(flush_o == 1'b0, "R1 flush single cycle", flush_o, 0);
    check(cts_o == 1'b1, "R1 cts raised", cts_o, 1);
    step_pins(2'b11);
    check(enable_o == 1'b1, "R2 re-enable after reset pin", enable_o, 1);
    measure(2000, "R1 interval back to default");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_disabled();
    t_pins();
    t_speeds();
    t_cts();
    t_zero();
    t_backpressure();
    t_reset_pin();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule